// File: doc/BRIEF.md
# Paged Display-Memory Access Arbiter

This block stands between a processor data bus and the storage of an on-screen display generator. The processor sees a 64-byte address window. Two areas of that window carry character bytes. A small group of registers near the top of the window controls the display. The character store holds 168 bytes, arranged as 8 display lines of 21 bytes. Because the window cannot show the whole store at once, a 2-bit line-select field picks one pair of neighbouring display lines. The even line of the pair appears in the lower area of the window and the odd line in the upper area.

The block also guards the store while the display uses it. While the ram-lock bit is set, writes to character bytes are refused. While the display-enable bit is set, writes to the six parameter registers are refused. The control register is always writable. A refused write leaves the target unchanged and raises a flag for one cycle. A second, read-only port lets the video side fetch any character byte by its linear index.

Top module: `osd_page_arbiter`

## Requirements
- R1: After reset all character bytes, parameter registers and control fields read zero, and `wr_reject` is low.
- R2: Offsets 00h..14h reach character byte 42·LS + offset, where LS is the line-select field. This is the even line 2·LS.
- R3: Offsets 20h..34h reach character byte 42·LS + 21 + (offset − 20h). This is the odd line 2·LS+1.
- R4: The control register at 3Fh is writable at any time. Bit 0 is display-enable, bit 1 is ram-lock and bits 3:2 are line-select. Bits 7:4 read as zero and are not stored.
- R5: The parameter registers at 38h..3Dh (index = offset − 38h) accept writes only while display-enable is 0. They can be read at any time.
- R6: Character-byte writes through either window are accepted only while ram-lock is 0.
- R7: A refused write changes no stored value. `wr_reject` is high in exactly the one cycle that follows the refused write.
- R8: Offsets 15h..1Fh, 35h..37h and 3Eh read as zero. Writes to them change nothing and do not raise `wr_reject`.
- R9: `vid_rdata` returns the character byte at linear index `vid_addr`, or zero when the index is 168 or above.
- R10: The parameter and control registers are reached at the same offsets whatever value line-select holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 6 | Processor offset in the window |
| cpu_we | input | 1 | Write strobe, one write per cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data for `cpu_addr` |
| wr_reject | output | 1 | One-cycle pulse after a refused write |
| vid_addr | input | 8 | Linear character index for the video side |
| vid_rdata | output | 8 | Character byte at `vid_addr` |
| disp_en | output | 1 | Display-enable bit |
| ram_lock | output | 1 | Ram-lock bit |
| line_sel | output | 2 | Line-select field |
| param_regs | output | 48 | The six parameter registers; register n is in bits 8n+7:8n |

## Verification
The bench targets the edges of both windows (offsets 00h, 14h, 20h, 34h) at the lowest and highest line-select values. An off-by-one in the paging arithmetic would land a byte in the wrong line, and the video port would show it there. It then sets each lock bit on its own and checks that only the matching class of write is refused. A design that swapped the two locks, or locked the control register, would either corrupt data or stay stuck in the locked state. Writes into the unmapped gaps, and the video index just past the end of the store, catch a decoder that aliases those offsets onto real storage or returns stale data.

// File: rtl/osd_arb_pkg.sv
package osd_arb_pkg;

  localparam int ADDR_W       = 6;
  localparam int DATA_W       = 8;
  localparam int LINE_BYTES   = 21;
  localparam int NUM_LINES    = 8;
  localparam int NUM_PARAM    = 6;
  localparam int RAM_DEPTH    = LINE_BYTES * NUM_LINES;
  localparam int PAIR_BYTES   = 2 * LINE_BYTES;
  localparam int RAM_AW       = $clog2(RAM_DEPTH);
  localparam int PARAM_AW     = $clog2(NUM_PARAM);
  localparam int LS_W         = $clog2(NUM_LINES / 2);

  localparam int EVEN_BASE    = 'h00;
  localparam int ODD_BASE     = 'h20;
  localparam int PARAM_BASE   = 'h38;
  localparam int CTRL_OFFSET  = 'h3F;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_RAM_EVEN,
    REG_RAM_ODD,
    REG_PARAM,
    REG_CTRL
  } region_e;

  typedef struct packed {
    logic [LS_W-1:0] line_sel;
    logic            ram_lock;
    logic            disp_en;
  } ctrl_t;

  function automatic region_e decode_offset(input logic [ADDR_W-1:0] a);
    int v;
    v = int'(a);
    if (v >= EVEN_BASE && v < EVEN_BASE + LINE_BYTES)      return REG_RAM_EVEN;
    else if (v >= ODD_BASE && v < ODD_BASE + LINE_BYTES)   return REG_RAM_ODD;
    else if (v >= PARAM_BASE && v < PARAM_BASE + NUM_PARAM) return REG_PARAM;
    else if (v == CTRL_OFFSET)                             return REG_CTRL;
    else                                                   return REG_NONE;
  endfunction

  function automatic logic [RAM_AW-1:0] ram_index(input logic [LS_W-1:0] ls,
                                                   input logic [ADDR_W-1:0] a,
                                                   input logic odd);
    int v;
    if (odd) v = PAIR_BYTES * int'(ls) + LINE_BYTES + (int'(a) - ODD_BASE);
    else     v = PAIR_BYTES * int'(ls) + (int'(a) - EVEN_BASE);
    return RAM_AW'(v);
  endfunction

  function automatic logic [PARAM_AW-1:0] param_index(input logic [ADDR_W-1:0] a);
    int v;
    v = int'(a) - PARAM_BASE;
    return PARAM_AW'(v);
  endfunction

endpackage

// File: rtl/osd_addr_decode.sv
module osd_addr_decode
  import osd_arb_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr,
  input  logic [LS_W-1:0]     line_sel,
  output region_e             region,
  output logic [RAM_AW-1:0]   ram_idx,
  output logic [PARAM_AW-1:0] param_idx
);

  always_comb begin
    region    = decode_offset(addr);
    ram_idx   = ram_index(line_sel, addr, region == REG_RAM_ODD);
    param_idx = param_index(addr);
  end

endmodule

// File: rtl/osd_char_ram.sv
module osd_char_ram #(
  parameter int DEPTH = 168,
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter int VAW   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [AW-1:0]  raddr,
  output logic [DW-1:0]  rdata,
  input  logic [VAW-1:0] vaddr,
  output logic [DW-1:0]  vdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && int'(waddr) < DEPTH) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;
    vdata = (int'(vaddr) < DEPTH) ? mem[vaddr] : '0;
  end

endmodule

// File: rtl/osd_glob_regs.sv
module osd_glob_regs
  import osd_arb_pkg::*;
#(
  parameter int NPARAM = 6,
  parameter int DW     = 8,
  parameter int PIW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              param_we,
  input  logic [PIW-1:0]    param_idx,
  input  logic              ctrl_we,
  input  logic [DW-1:0]     wdata,
  output logic [NPARAM*DW-1:0] param_flat,
  output ctrl_t             ctrl
);

  for (genvar g = 0; g < NPARAM; g++) begin : g_param
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= '0;
      else if (param_we && int'(param_idx) == g)   q <= wdata;
    end
    assign param_flat[g*DW +: DW] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_we) ctrl <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
  end

endmodule

// File: rtl/osd_page_arbiter.sv
module osd_page_arbiter
  import osd_arb_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int DW     = DATA_W,
  parameter int NPARAM = NUM_PARAM,
  parameter int VAW    = RAM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_we,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              wr_reject,
  input  logic [VAW-1:0]    vid_addr,
  output logic [DW-1:0]     vid_rdata,
  output logic              disp_en,
  output logic              ram_lock,
  output logic [LS_W-1:0]   line_sel,
  output logic [NPARAM*DW-1:0] param_regs
);

  region_e             region_w;
  logic [RAM_AW-1:0]   ram_idx_w;
  logic [PARAM_AW-1:0] param_idx_w;
  logic [DW-1:0]       ram_rdata_w;
  ctrl_t               ctrl_q;

  // Named events for the checker.
  logic ram_hit_w, param_hit_w, ctrl_hit_w;
  logic ram_wr_ok_w, param_wr_ok_w, wr_blocked_w;

  osd_addr_decode u_dec (
    .addr      (cpu_addr),
    .line_sel  (ctrl_q.line_sel),
    .region    (region_w),
    .ram_idx   (ram_idx_w),
    .param_idx (param_idx_w)
  );

  assign ram_hit_w     = (region_w == REG_RAM_EVEN) || (region_w == REG_RAM_ODD);
  assign param_hit_w   = (region_w == REG_PARAM);
  assign ctrl_hit_w    = (region_w == REG_CTRL);
  assign ram_wr_ok_w   = cpu_we && ram_hit_w && !ctrl_q.ram_lock;
  assign param_wr_ok_w = cpu_we && param_hit_w && !ctrl_q.disp_en;
  assign wr_blocked_w  = cpu_we && ((ram_hit_w && ctrl_q.ram_lock) ||
                                    (param_hit_w && ctrl_q.disp_en));

  osd_char_ram #(
    .DEPTH (RAM_DEPTH),
    .DW    (DW),
    .AW    (RAM_AW),
    .VAW   (VAW)
  ) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_wr_ok_w),
    .waddr (ram_idx_w),
    .wdata (cpu_wdata),
    .raddr (ram_idx_w),
    .rdata (ram_rdata_w),
    .vaddr (vid_addr),
    .vdata (vid_rdata)
  );

  osd_glob_regs #(
    .NPARAM (NPARAM),
    .DW     (DW),
    .PIW    (PARAM_AW)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .param_we   (param_wr_ok_w),
    .param_idx  (param_idx_w),
    .ctrl_we    (cpu_we && ctrl_hit_w),
    .wdata      (cpu_wdata),
    .param_flat (param_regs),
    .ctrl       (ctrl_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_reject <= 1'b0;
    else        wr_reject <= wr_blocked_w;
  end

  always_comb begin
    unique case (region_w)
      REG_RAM_EVEN, REG_RAM_ODD: cpu_rdata = ram_rdata_w;
      REG_PARAM: cpu_rdata = param_regs[int'(param_idx_w)*DW +: DW];
      REG_CTRL:  cpu_rdata = DW'(ctrl_q);
      default:   cpu_rdata = '0;
    endcase
  end

  assign disp_en  = ctrl_q.disp_en;
  assign ram_lock = ctrl_q.ram_lock;
  assign line_sel = ctrl_q.line_sel;

endmodule

// File: rtl/osd_arb_checker.sv
module osd_arb_checker
  import osd_arb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int PW = NUM_PARAM * DATA_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_we,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic          wr_reject,
  input logic          disp_en,
  input logic          ram_lock,
  input logic [LS_W-1:0] line_sel,
  input logic [PW-1:0] param_regs,
  input region_e       region_w
);

  assert_ram_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && (region_w == REG_RAM_EVEN || region_w == REG_RAM_ODD) && ram_lock) |=> wr_reject);

  assert_param_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && region_w == REG_PARAM && disp_en) |=> ($stable(param_regs) && wr_reject));

  assert_ctrl_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == AW'(CTRL_OFFSET)) |=>
      (disp_en == $past(cpu_wdata[0]) && ram_lock == $past(cpu_wdata[1]) &&
       line_sel == $past(cpu_wdata[2 +: LS_W]) && !wr_reject));

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (region_w == REG_NONE) |-> (cpu_rdata == '0));

  assert_unmapped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && region_w == REG_NONE) |=> (!wr_reject && $stable(param_regs)));

  assert_reject_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |=> !wr_reject);

endmodule

bind osd_page_arbiter osd_arb_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_addr   (cpu_addr),
  .cpu_we     (cpu_we),
  .cpu_wdata  (cpu_wdata),
  .cpu_rdata  (cpu_rdata),
  .wr_reject  (wr_reject),
  .disp_en    (disp_en),
  .ram_lock   (ram_lock),
  .line_sel   (line_sel),
  .param_regs (param_regs),
  .region_w   (region_w)
);

// File: tb/test_osd_page_arbiter.sv
`timescale 1ns/1ps
module test_osd_page_arbiter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        wr_reject;
  logic [7:0]  vid_addr = '0;
  logic [7:0]  vid_rdata;
  logic        disp_en, ram_lock;
  logic [1:0]  line_sel;
  logic [47:0] param_regs;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic last_reject;

  always #4 clk = ~clk;

  osd_page_arbiter i_osd_page_arbiter (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .wr_reject(wr_reject),
    .vid_addr(vid_addr), .vid_rdata(vid_rdata), .disp_en(disp_en),
    .ram_lock(ram_lock), .line_sel(line_sel), .param_regs(param_regs)
  );

  // Vector: {op[1:0], addr[7:0], data[7:0], exp[7:0]}; op 0 write, 1 cpu read, 2 video read.
  localparam int NV = 34;
  localparam logic [25:0] VEC [0:NV-1] = '{
    {2'd0, 8'h3F, 8'h04, 8'h00},  // LS=1
    {2'd0, 8'h00, 8'hA1, 8'h00},  // R2 -> idx 42
    {2'd0, 8'h14, 8'hA2, 8'h00},  // R2 -> idx 62
    {2'd0, 8'h20, 8'hB1, 8'h00},  // R3 -> idx 63
    {2'd0, 8'h34, 8'hB2, 8'h00},  // R3 -> idx 83
    {2'd2, 8'd42, 8'h00, 8'hA1},
    {2'd2, 8'd62, 8'h00, 8'hA2},
    {2'd2, 8'd63, 8'h00, 8'hB1},
    {2'd2, 8'd83, 8'h00, 8'hB2},
    {2'd1, 8'h00, 8'h00, 8'hA1},
    {2'd1, 8'h34, 8'h00, 8'hB2},
    {2'd0, 8'h3F, 8'h0C, 8'h00},  // LS=3
    {2'd1, 8'h00, 8'h00, 8'h00},  // new page is empty
    {2'd0, 8'h00, 8'hC3, 8'h00},  // idx 126
    {2'd0, 8'h34, 8'hD3, 8'h00},  // idx 167
    {2'd2, 8'd126, 8'h00, 8'hC3},
    {2'd2, 8'd167, 8'h00, 8'hD3},
    {2'd2, 8'd168, 8'h00, 8'h00}, // R9 past end
    {2'd1, 8'h3F, 8'h00, 8'h0C},
    {2'd0, 8'h3F, 8'hFC, 8'h00},  // R4 upper bits dropped
    {2'd1, 8'h3F, 8'h00, 8'h0C},
    {2'd0, 8'h38, 8'h55, 8'h00},  // R10 with LS=3
    {2'd1, 8'h38, 8'h00, 8'h55},
    {2'd0, 8'h3D, 8'h66, 8'h00},
    {2'd1, 8'h3D, 8'h00, 8'h66},
    {2'd0, 8'h15, 8'h77, 8'h00},  // R8 gaps
    {2'd0, 8'h3E, 8'h11, 8'h00},
    {2'd0, 8'h35, 8'h12, 8'h00},
    {2'd1, 8'h15, 8'h00, 8'h00},
    {2'd1, 8'h3E, 8'h00, 8'h00},
    {2'd1, 8'h35, 8'h00, 8'h00},
    {2'd0, 8'h3F, 8'h00, 8'h00},  // LS=0
    {2'd0, 8'h00, 8'h11, 8'h00},  // idx 0
    {2'd2, 8'd0,  8'h00, 8'h11}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    last_reject = wr_reject;
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic vid_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    vid_addr = a;
    #1 d = vid_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reject", 64'(wr_reject), 64'd0);
    check("R1 ctrl", {disp_en, ram_lock, line_sel}, 64'd0);
    check("R1 params", 64'(param_regs), 64'd0);
    rst_n = 1'b1;
    cpu_read(6'h3F, d); check("R1 ctrl read", 64'(d), 64'd0);
    vid_read(8'd100, d); check("R1 ram", 64'(d), 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] a, wd, ex;
      {op, a, wd, ex} = VEC[i];
      if (op == 2'd0) begin
        do_write(a[5:0], wd);
        check("R7/R8 no reject on accepted write", 64'(last_reject), 64'd0);
      end else if (op == 2'd1) begin
        cpu_read(a[5:0], d);
        check("R2/R3/R4/R5/R8/R10 cpu read", 64'(d), 64'(ex));
      end else begin
        vid_read(a, d);
        check("R2/R3/R9 video read", 64'(d), 64'(ex));
      end
    end

    // R4 control fields on outputs
    do_write(6'h3F, 8'h03);
    check("R4 fields", {disp_en, ram_lock, line_sel}, {1'b1, 1'b1, 2'b00});
    // R6 + R7: RAM write refused while locked
    do_write(6'h00, 8'hEE);
    check("R7 reject pulse", 64'(last_reject), 64'd1);
    @(negedge clk);
    check("R7 pulse one cycle", 64'(wr_reject), 64'd0);
    cpu_read(6'h00, d); check("R6 ram unchanged", 64'(d), 64'h11);
    vid_read(8'd0, d);  check("R6 ram unchanged video", 64'(d), 64'h11);
    // R5: param write refused while enabled
    do_write(6'h38, 8'h99);
    check("R5 reject", 64'(last_reject), 64'd1);
    cpu_read(6'h38, d); check("R5 param unchanged", 64'(d), 64'h55);
    // R4: control writable while both locks set
    do_write(6'h3F, 8'h01);
    check("R4 ctrl always writable", 64'(last_reject), 64'd0);
    check("R4 lock cleared", {disp_en, ram_lock}, {1'b1, 1'b0});
    // R6: RAM accepted with lock clear, R5 still blocked by enable
    do_write(6'h00, 8'h22);
    check("R6 accepted", 64'(last_reject), 64'd0);
    cpu_read(6'h00, d); check("R6 ram written", 64'(d), 64'h22);
    do_write(6'h39, 8'h44);
    check("R5 reject with enable only", 64'(last_reject), 64'd1);
    // R5 accepted / R6 blocked with lock only
    do_write(6'h3F, 8'h02);
    do_write(6'h39, 8'h44);
    check("R5 accepted", 64'(last_reject), 64'd0);
    check("R5 param port", 64'(param_regs[15:8]), 64'h44);
    do_write(6'h20, 8'h5A);
    check("R6 odd window blocked", 64'(last_reject), 64'd1);
    vid_read(8'd21, d); check("R6 odd unchanged", 64'(d), 64'h00);
    // R8: gap write while locked gives no reject
    do_write(6'h1F, 8'h33);
    check("R8 no reject", 64'(last_reject), 64'd0);
    cpu_read(6'h1F, d); check("R8 gap reads zero", 64'(d), 64'h00);

    finish_run();
  end

endmodule